// File: doc/BRIEF.md
# Converter Power-Down and Start-Up Sequencer

This block decides when the sampling datapath of a stereo audio converter may run. A single active-low power-down input, sampled on the master clock, takes the block back to power-down from any state. In power-down the decimation filters are held in reset, the serial data pin and any master-mode frame and bit clock pins are forced low, and sample data is forced to two's-complement zero.

When power-down is released, the sequencer starts. As a clock master it starts at once. As a clock slave it waits for the first frame-clock edge whose polarity marks a frame start in the selected serial format. Until that edge it stays in power-down. It then counts a fixed number of frame-clock edges, which differs between master and slave. During the count, sample data stays at zero. Once the count completes, the data is marked valid.

Frame-clock edges arrive as one-cycle strobes that are already synchronous to the master clock. Power-down pulses shorter than a set number of clocks are treated as noise.

Top module: `pdn_init_seq`

## Requirements
- R1: While rst_ni is low, filt_rst_o, pins_low_o and zero_data_o are 1 and data_valid_o is 0, whatever pdn_ni is.
- R2: If pdn_ni is held low for at least MIN_LOW clocks, the block enters power-down from any state within SYNC_STAGES+MIN_LOW+2 clocks. Power-down means filt_rst_o=1, pins_low_o=1, zero_data_o=1 and data_valid_o=0.
- R3: A low pulse on pdn_ni shorter than MIN_LOW clocks has no effect on any output.
- R4: In master mode (master_i=1), leaving power-down drops filt_rst_o and pins_low_o without waiting for an edge. data_valid_o then rises on the clock after the INIT_MASTER-th framing edge, and zero_data_o stays 1 until that point.
- R5: In slave mode (master_i=0), filt_rst_o and pins_low_o stay 1 until the first framing edge. That start edge is not counted. data_valid_o rises on the clock after INIT_SLAVE further framing edges.
- R6: The framing edge is a rising strobe (lr_rise_i) when i2s_i=0 and a falling strobe (lr_fall_i) when i2s_i=1. Strobes of the other polarity neither start nor advance the sequence.
- R7: master_i and i2s_i are captured only while in power-down. Changing them afterwards does not alter the count or the edge polarity until the next power-down.
- R8: Once valid, data_valid_o stays 1 and the other three outputs stay 0 under further frame-clock strobes of either polarity, until the next power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pdn_ni | input | 1 | Asynchronous active-low power-down request |
| lr_rise_i | input | 1 | One-cycle strobe on a frame-clock rising edge |
| lr_fall_i | input | 1 | One-cycle strobe on a frame-clock falling edge |
| master_i | input | 1 | 1: clock master, 0: clock slave |
| i2s_i | input | 1 | 1: I2S framing, 0: MSB-justified framing |
| filt_rst_o | output | 1 | Holds decimation filters in reset |
| pins_low_o | output | 1 | Forces serial data and master clock pins low |
| zero_data_o | output | 1 | Forces sample data to two's-complement zero |
| data_valid_o | output | 1 | Sample data is valid |

## Verification
The bench builds the block with INIT_MASTER=9 and INIT_SLAVE=12, keeping MIN_LOW=4 and SYNC_STAGES=2. With these counts, dozens of complete power-down, start and count sequences fit into a short run. That covers all four combinations of clocking mode and framing, wrong-polarity strobes mixed randomly into the count, and mode flips in the middle of a count. Because MIN_LOW is short, every pulse length below the filter threshold can be tried, along with power-down requests that arrive during a count.

// File: rtl/pdn_seq_pkg.sv
package pdn_seq_pkg;
  typedef enum logic [1:0] {
    ST_DOWN  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_COUNT = 2'd2,
    ST_RUN   = 2'd3
  } seq_st_e;
endpackage

// File: rtl/pdn_deglitch.sv
module pdn_deglitch #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pdn_ni,
  output logic pdn_up_o
);
  localparam int LW = $clog2(MIN_LOW + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [LW-1:0]          low_cnt_q;
  logic                   up_q;
  logic                   pdn_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pdn_ni};
  end

  assign pdn_s = sync_q[SYNC_STAGES-1];

  // release is immediate, entry needs MIN_LOW low samples in a row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt_q <= '0;
      up_q      <= 1'b0;
    end else if (pdn_s) begin
      low_cnt_q <= '0;
      up_q      <= 1'b1;
    end else if (low_cnt_q == LW'(MIN_LOW - 1)) begin
      up_q      <= 1'b0;
    end else begin
      low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  assign pdn_up_o = up_q;
endmodule

// File: rtl/frame_edge_sel.sv
module frame_edge_sel (
  input  logic rise_i,
  input  logic fall_i,
  input  logic i2s_i,
  output logic edge_o
);
  assign edge_o = i2s_i ? fall_i : rise_i;
endmodule

// File: rtl/init_counter.sv
module init_counter #(
  parameter int CNT_W       = 13,
  parameter int INIT_MASTER = 4129,
  parameter int INIT_SLAVE  = 4132
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  input  logic master_i,
  output logic last_o
);
  localparam logic [CNT_W-1:0] TC_M = CNT_W'(INIT_MASTER - 1);
  localparam logic [CNT_W-1:0] TC_S = CNT_W'(INIT_SLAVE - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tc;

  assign tc = master_i ? TC_M : TC_S;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = step_i && (cnt_q == tc);
endmodule

// File: rtl/pdn_init_seq.sv
module pdn_init_seq
  import pdn_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 4,
  parameter int CNT_W       = 13,
  parameter int INIT_MASTER = 4129,
  parameter int INIT_SLAVE  = 4132
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pdn_ni,
  input  logic lr_rise_i,
  input  logic lr_fall_i,
  input  logic master_i,
  input  logic i2s_i,
  output logic filt_rst_o,
  output logic pins_low_o,
  output logic zero_data_o,
  output logic data_valid_o
);
  seq_st_e st_q, st_d;
  logic    pdn_up;
  logic    master_q, i2s_q;
  logic    frame_edge;
  logic    cnt_last;
  logic    go_master;

  pdn_deglitch #(
    .SYNC_STAGES(SYNC_STAGES),
    .MIN_LOW    (MIN_LOW)
  ) i_deglitch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pdn_ni  (pdn_ni),
    .pdn_up_o(pdn_up)
  );

  frame_edge_sel i_edge_sel (
    .rise_i(lr_rise_i),
    .fall_i(lr_fall_i),
    .i2s_i (i2s_q),
    .edge_o(frame_edge)
  );

  init_counter #(
    .CNT_W      (CNT_W),
    .INIT_MASTER(INIT_MASTER),
    .INIT_SLAVE (INIT_SLAVE)
  ) i_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (st_q != ST_COUNT),
    .step_i  ((st_q == ST_COUNT) && frame_edge),
    .master_i(master_q),
    .last_o  (cnt_last)
  );

  // mode is tracked only while powered down
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_q <= 1'b0;
      i2s_q    <= 1'b0;
    end else if (st_q == ST_DOWN) begin
      master_q <= master_i;
      i2s_q    <= i2s_i;
    end
  end

  assign go_master = master_i;

  always_comb begin
    st_d = st_q;
    if (!pdn_up) begin
      st_d = ST_DOWN;
    end else begin
      unique case (st_q)
        ST_DOWN:  st_d = go_master ? ST_COUNT : ST_WAIT;
        ST_WAIT:  if (frame_edge) st_d = ST_COUNT;
        ST_COUNT: if (cnt_last)   st_d = ST_RUN;
        ST_RUN:   st_d = ST_RUN;
        default:  st_d = ST_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_DOWN;
    else         st_q <= st_d;
  end

  assign filt_rst_o   = (st_q == ST_DOWN) || (st_q == ST_WAIT);
  assign pins_low_o   = (st_q == ST_DOWN) || (st_q == ST_WAIT);
  assign zero_data_o  = (st_q != ST_RUN);
  assign data_valid_o = (st_q == ST_RUN);
endmodule

module pdn_init_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pdn_up,
  input logic master_q,
  input logic i2s_q,
  input logic lr_rise_i,
  input logic lr_fall_i,
  input logic filt_rst_o,
  input logic pins_low_o,
  input logic zero_data_o,
  input logic data_valid_o
);
  // R2
  pd_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdn_up |=> filt_rst_o && pins_low_o && zero_data_o && !data_valid_o);

  // R3
  pd_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(filt_rst_o) |-> $past(!pdn_up));

  // R4
  valid_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_valid_o) |-> $past(i2s_q ? lr_fall_i : lr_rise_i));

  // R5
  slave_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(filt_rst_o) && !master_q |-> $past(i2s_q ? lr_fall_i : lr_rise_i));

  // R7
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o && $past(data_valid_o) |-> $stable(master_q) && $stable(i2s_q));
endmodule

bind pdn_init_seq pdn_init_seq_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pdn_up      (pdn_up),
  .master_q    (master_q),
  .i2s_q       (i2s_q),
  .lr_rise_i   (lr_rise_i),
  .lr_fall_i   (lr_fall_i),
  .filt_rst_o  (filt_rst_o),
  .pins_low_o  (pins_low_o),
  .zero_data_o (zero_data_o),
  .data_valid_o(data_valid_o)
);

// File: tb/test_pdn_init_seq.sv
module test_pdn_init_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int MIN_LOW    = 4;
  localparam int N_M        = 9;
  localparam int N_S        = 12;

  logic clk_i = 1'b0;
  logic rst_ni, pdn_ni, lr_rise_i, lr_fall_i, master_i, i2s_i;
  logic filt_rst_o, pins_low_o, zero_data_o, data_valid_o;
  int   total = 0;
  int   bad   = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  pdn_init_seq #(
    .SYNC_STAGES(SYNC),
    .MIN_LOW    (MIN_LOW),
    .CNT_W      (13),
    .INIT_MASTER(N_M),
    .INIT_SLAVE (N_S)
  ) i_pdn_init_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pdn_ni      (pdn_ni),
    .lr_rise_i   (lr_rise_i),
    .lr_fall_i   (lr_fall_i),
    .master_i    (master_i),
    .i2s_i       (i2s_i),
    .filt_rst_o  (filt_rst_o),
    .pins_low_o  (pins_low_o),
    .zero_data_o (zero_data_o),
    .data_valid_o(data_valid_o)
  );

  // phase: 0 down, 1 waiting for start edge, 2 counting, 3 valid
  // flags: {filt_rst, pins_low, zero_data, data_valid}
  function automatic logic [3:0] exp_flags(int ph);
    case (ph)
      0, 1:    return 4'b1110;
      2:       return 4'b0010;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic logic [3:0] outs();
    return {filt_rst_o, pins_low_o, zero_data_o, data_valid_o};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(string req, logic [3:0] got, logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic pulse(bit rise);
    lr_rise_i = rise;
    lr_fall_i = !rise;
    tick(1);
    lr_rise_i = 1'b0;
    lr_fall_i = 1'b0;
  endtask

  task automatic gap();
    tick($urandom_range(0, 2));
  endtask

  task automatic power_down(string req);
    pdn_ni = 1'b0;
    tick(SYNC + MIN_LOW + 2);
    chk(req, outs(), exp_flags(0));
  endtask

  task automatic release_pd(bit m, bit f);
    master_i = m;
    i2s_i    = f;
    tick(2);
    pdn_ni = 1'b1;
    tick(SYNC + 3);
    if (m) chk("R4 master leaves power-down", outs(), exp_flags(2));
    else   chk("R5 slave waits for start edge", outs(), exp_flags(1));
  endtask

  task automatic run_seq(bit m, bit f, bit flip);
    int n;
    int k;
    power_down("R2 entry");
    release_pd(m, f);
    if (!m) begin
      pulse(f);  // wrong polarity: rise when i2s, fall otherwise
      chk("R6 wrong edge does not start", outs(), exp_flags(1));
      gap();
      pulse(!f);
      chk("R5 start edge", outs(), exp_flags(2));
      gap();
    end
    n = m ? N_M : N_S;
    k = 0;
    while (k < n) begin
      if ($urandom_range(0, 2) == 0) begin
        pulse(f);
        chk("R6 wrong edge ignored", outs(), exp_flags(2));
      end else begin
        pulse(!f);
        k++;
        if (m) chk("R4 master count", outs(), exp_flags(k >= n ? 3 : 2));
        else   chk("R5 slave count", outs(), exp_flags(k >= n ? 3 : 2));
        if (flip && k == 2) begin
          master_i = !m;
          i2s_i    = !f;
        end
      end
      gap();
    end
    for (int i = 0; i < 4; i++) begin
      pulse($urandom_range(0, 1) == 1);
      chk(flip ? "R7 mode flip ignored" : "R8 valid holds", outs(), exp_flags(3));
      gap();
    end
    master_i = m;
    i2s_i    = f;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_ni = 1'b0; pdn_ni = 1'b1; lr_rise_i = 1'b0; lr_fall_i = 1'b0;
    master_i = 1'b1; i2s_i = 1'b0;
    tick(3);
    chk("R1 reset state", outs(), exp_flags(0));
    rst_ni = 1'b1;

    run_seq(1'b1, 1'b0, 1'b0);
    for (int len = 1; len < MIN_LOW; len++) begin
      pdn_ni = 1'b0;
      tick(len);
      pdn_ni = 1'b1;
      tick(SYNC + MIN_LOW + 3);
      chk("R3 short low pulse ignored", outs(), exp_flags(3));
    end
    power_down("R2 from valid");

    run_seq(1'b0, 1'b0, 1'b0);
    run_seq(1'b0, 1'b1, 1'b0);
    run_seq(1'b1, 1'b1, 1'b1);
    run_seq(1'b0, 1'b1, 1'b1);
    run_seq(1'b0, 1'b0, 1'b1);

    // power-down in the middle of a count
    power_down("R2 entry");
    release_pd(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      pulse(1'b1);
      gap();
    end
    chk("R4 mid count", outs(), exp_flags(2));
    power_down("R2 from counting");
    release_pd(1'b1, 1'b0);
    for (int i = 0; i < N_M - 1; i++) begin
      pulse(1'b1);
      gap();
    end
    chk("R4 count restarts after power-down", outs(), exp_flags(2));
    pulse(1'b1);
    chk("R4 count complete", outs(), exp_flags(3));

    for (int i = 0; i < 8; i++)
      run_seq($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
              $urandom_range(0, 1) == 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule